// File: doc/BRIEF.md
# Legacy Interrupt Line Router

This block connects the interrupt requests of four peripheral functions (a floppy controller, a parallel port, a UART and a keyboard controller) to a shared bank of sixteen ISA-style interrupt lines. Each function has a 4-bit level-select register. Software reaches these registers through a two-address configuration port. It first writes a register index to the index address. It then reads or writes the data address. A device-number register, itself reached through the same port, chooses which function's select register the data address reaches.

A function claims its chosen line only when its select value is non-zero and its own enable condition holds. The enable bits come from the peripheral's registers, and they arrive here as plain input buses. Every line has a value output and a separate output-enable. A line that no active function claims is released (enable low). When two functions pick the same line, a conflict flag rises and the line carries the OR of the requests of the functions that are active on it.

Top module: `irq_router`

## Requirements
- R1: After reset the index register, the device number and all four select registers are zero, and every line's output-enable is low.
- R2: A write to the data address (cfg_addr=1) takes effect on the next clock edge. At index 0x07 it stores wdata[1:0] as the device number (0 floppy, 1 parallel, 2 UART, 3 keyboard). At index 0x70 it stores wdata[3:0] as that device's select. At any other index it changes nothing.
- R3: A read at cfg_addr=0 returns the index register. At cfg_addr=1 it returns the device number at index 0x07, the selected device's select value in bits [3:0] with bits [7:4] zero at index 0x70, and zero at any other index.
- R4: A select value of 0 routes nothing. A value k from 1 to 15 makes an active function drive line k, and line 0 is never driven.
- R5: The floppy function is active only while bit 3 of fdc_dor is set.
- R6: The parallel function needs bit 4 of pp_ctrl set. While pp_ecp is high it also needs bit 2 of pp_ecr clear.
- R7: The UART function needs at least one of uart_ier[3:0] set and bit 3 of uart_mcr set.
- R8: The keyboard function has no extra condition and is active whenever its select is non-zero.
- R9: A line that no active function claims has output-enable low and value low.
- R10: The parallel request is active-high in normal mode. While pp_ecp or pp_epp is high it is active-low and is inverted before it reaches the line.
- R11: irq_conflict is high exactly when two functions hold the same non-zero select. The shared line then carries the OR of the requests of the active functions on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 1 | 0 = index address, 1 = data address |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration read data |
| fdc_dor | input | 8 | Floppy digital output register |
| fdc_req | input | 1 | Floppy request |
| pp_ctrl | input | 8 | Parallel control register |
| pp_ecr | input | 8 | Parallel extended control register |
| pp_ecp | input | 1 | Parallel port in ECP mode |
| pp_epp | input | 1 | Parallel port in EPP mode |
| pp_req | input | 1 | Parallel request (polarity per R10) |
| uart_ier | input | 8 | UART interrupt-enable register |
| uart_mcr | input | 8 | UART modem-control register |
| uart_req | input | 1 | UART request |
| kbd_req | input | 1 | Keyboard request |
| irq_val | output | 16 | Value driven on each line |
| irq_oe | output | 16 | Output-enable of each line |
| irq_conflict | output | 1 | Two functions share a non-zero select |

## Verification
The assertions check on every cycle that a select write lands one edge later, that line 0 stays released, that a released line carries no value, that the keyboard's select line is claimed whenever that select is non-zero, and that without a conflict the number of claimed lines equals the number of active functions. Only the bench's scenarios can show that each gating condition blocks or passes its function, that ECP and EPP mode flip the parallel polarity, that writes at unknown indices leave the readback unchanged, and that a shared line ORs its requests. A behavioural model compares the lines, the conflict flag and the readback on every clock.

// File: rtl/irq_router.sv
module irq_router #(
  parameter int         LINES   = 16,
  parameter int         SELW    = 4,
  parameter logic [7:0] IDX_DEV = 8'h07,
  parameter logic [7:0] IDX_SEL = 8'h70
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic             cfg_addr,
  input  logic [7:0]       cfg_wdata,
  output logic [7:0]       cfg_rdata,
  input  logic [7:0]       fdc_dor,
  input  logic             fdc_req,
  input  logic [7:0]       pp_ctrl,
  input  logic [7:0]       pp_ecr,
  input  logic             pp_ecp,
  input  logic             pp_epp,
  input  logic             pp_req,
  input  logic [7:0]       uart_ier,
  input  logic [7:0]       uart_mcr,
  input  logic             uart_req,
  input  logic             kbd_req,
  output logic [LINES-1:0] irq_val,
  output logic [LINES-1:0] irq_oe,
  output logic             irq_conflict
);
  localparam int NF = 4;
  localparam int DW = $clog2(NF);

  logic [7:0]               idx;
  logic [DW-1:0]            dev;
  logic [NF-1:0][SELW-1:0]  sel;
  logic [NF-1:0]            en, req, active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx <= '0;
      dev <= '0;
      sel <= '0;
    end else if (cfg_wr) begin
      if (!cfg_addr)              idx      <= cfg_wdata;
      else if (idx == IDX_DEV)    dev      <= cfg_wdata[DW-1:0];
      else if (idx == IDX_SEL)    sel[dev] <= cfg_wdata[SELW-1:0];
    end
  end

  always_comb begin
    cfg_rdata = '0;
    if (!cfg_addr)              cfg_rdata = idx;
    else if (idx == IDX_DEV)    cfg_rdata[DW-1:0] = dev;
    else if (idx == IDX_SEL)    cfg_rdata[SELW-1:0] = sel[dev];
  end

  assign en[0]  = fdc_dor[3];
  assign en[1]  = pp_ctrl[4] && !(pp_ecp && pp_ecr[2]);
  assign en[2]  = (|uart_ier[3:0]) && uart_mcr[3];
  assign en[3]  = 1'b1;
  assign req[0] = fdc_req;
  assign req[1] = (pp_ecp || pp_epp) ? ~pp_req : pp_req;
  assign req[2] = uart_req;
  assign req[3] = kbd_req;

  for (genvar f = 0; f < NF; f++) begin : g_act
    assign active[f] = en[f] && (sel[f] != '0);
  end

  always_comb begin
    irq_oe  = '0;
    irq_val = '0;
    for (int f = 0; f < NF; f++)
      if (active[f]) begin
        irq_oe[sel[f]]  = 1'b1;
        irq_val[sel[f]] = irq_val[sel[f]] | req[f];
      end
  end

  always_comb begin
    irq_conflict = 1'b0;
    for (int i = 0; i < NF; i++)
      for (int j = i + 1; j < NF; j++)
        if (sel[i] != '0 && sel[i] == sel[j]) irq_conflict = 1'b1;
  end

  assert_sel_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_addr && idx == IDX_SEL) |=> sel[$past(dev)] == $past(cfg_wdata[SELW-1:0]));

  assert_line0_free_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_oe[0]);

  assert_released_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_val & ~irq_oe) == '0);

  assert_kbd_claims_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sel[3] != '0) |-> irq_oe[sel[3]]);

  assert_line_count_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_conflict |-> $countones(irq_oe) == $countones(active));
endmodule

// File: tb/irq_router_tb_top.sv
module irq_router_tb_top;
  logic clk = 0, rst_n = 0;
  logic cfg_wr = 0, cfg_addr = 0;
  logic [7:0] cfg_wdata = 0, cfg_rdata;
  logic [7:0] fdc_dor = 0, pp_ctrl = 0, pp_ecr = 0, uart_ier = 0, uart_mcr = 0;
  logic fdc_req = 0, pp_ecp = 0, pp_epp = 0, pp_req = 0, uart_req = 0, kbd_req = 0;
  logic [15:0] irq_val, irq_oe;
  logic irq_conflict;
  int checks = 0, fails = 0;
  bit done = 0;

  int m_idx = 0, m_dev = 0;
  int m_sel [4] = '{0, 0, 0, 0};

  always #4 clk = ~clk;

  irq_router dut_i (.*);

  task automatic chk(string rq, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h t=%0t", rq, act, exp, $time);
    end
  endtask

  always @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      m_idx = 0; m_dev = 0; m_sel = '{0, 0, 0, 0};
    end else if (cfg_wr) begin
      if (!cfg_addr) m_idx = cfg_wdata;
      else if (m_idx == 8'h07) m_dev = cfg_wdata % 4;
      else if (m_idx == 8'h70) m_sel[m_dev] = cfg_wdata % 16;
    end

  function automatic bit f_on(int f);
    case (f)
      0: return fdc_dor[3];
      1: return pp_ctrl[4] && !(pp_ecp && pp_ecr[2]);
      2: return (uart_ier % 16 != 0) && uart_mcr[3];
      default: return 1;
    endcase
  endfunction

  function automatic bit f_req(int f);
    case (f)
      0: return fdc_req;
      1: return (pp_ecp || pp_epp) ? !pp_req : pp_req;
      2: return uart_req;
      default: return kbd_req;
    endcase
  endfunction

  always @(negedge clk) if (rst_n && !done) begin
    logic [15:0] eo, ev;
    bit ec;
    logic [7:0] er;
    eo = 0; ev = 0; ec = 0;
    for (int f = 0; f < 4; f++) begin
      if (m_sel[f] != 0 && f_on(f)) begin
        eo[m_sel[f]] = 1;
        if (f_req(f)) ev[m_sel[f]] = 1;
      end
      for (int g = f + 1; g < 4; g++)
        if (m_sel[f] != 0 && m_sel[f] == m_sel[g]) ec = 1;
    end
    if (!cfg_addr) er = m_idx[7:0];
    else if (m_idx == 8'h07) er = m_dev[7:0];
    else if (m_idx == 8'h70) er = m_sel[m_dev][7:0];
    else er = 0;
    chk("R4 oe", irq_oe, eo);
    chk("R9 val", irq_val, ev);
    chk("R11 conflict", irq_conflict, ec);
    chk("R3 rdata", cfg_rdata, er);
  end

  task automatic wr(bit a, logic [7:0] d);
    @(posedge clk) #1;
    cfg_wr = 1; cfg_addr = a; cfg_wdata = d;
    @(posedge clk) #1;
    cfg_wr = 0;
  endtask

  task automatic set_sel(int dev, int s);
    wr(0, 8'h07); wr(1, dev[7:0]);
    wr(0, 8'h70); wr(1, s[7:0]);
  endtask

  task automatic settle;
    @(negedge clk); #1;
  endtask

  task automatic finish_run;
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    fails++; checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    settle();
    chk("R1 oe after reset", irq_oe, 0);
    cfg_addr = 1; settle();
    chk("R1 data read after reset", cfg_rdata, 0);

    // R5 floppy on line 6
    set_sel(0, 6); fdc_req = 1; settle();
    chk("R5 floppy blocked", irq_oe[6], 0);
    fdc_dor = 8'h08; settle();
    chk("R5 floppy driving", {irq_oe[6], irq_val[6]}, 2'b11);

    // R3 upper bits read zero
    wr(1, 8'hF6); cfg_addr = 1; settle();
    chk("R3 select upper bits zero", cfg_rdata, 8'h06);

    // R2 unknown index ignored
    wr(0, 8'h55); wr(1, 8'h3C); wr(0, 8'h70); cfg_addr = 1; settle();
    chk("R2 unknown index no effect", cfg_rdata, 8'h06);
    wr(0, 8'h07); cfg_addr = 1; settle();
    chk("R2 device readback", cfg_rdata, 8'h00);

    // R6 parallel on line 7
    set_sel(1, 7); pp_req = 1; settle();
    chk("R6 parallel no irq enable", irq_oe[7], 0);
    pp_ctrl = 8'h10; settle();
    chk("R6 parallel enabled", {irq_oe[7], irq_val[7]}, 2'b11);
    pp_ecp = 1; pp_ecr = 8'h04; settle();
    chk("R6 ecp service bit blocks", irq_oe[7], 0);
    pp_ecr = 8'h00; pp_req = 0; settle();
    chk("R10 ecp active-low", {irq_oe[7], irq_val[7]}, 2'b11);
    pp_ecp = 0; pp_epp = 1; pp_req = 1; settle();
    chk("R10 epp inverted", {irq_oe[7], irq_val[7]}, 2'b10);
    pp_epp = 0;

    // R7 UART on line 4
    set_sel(2, 4); uart_req = 1; uart_mcr = 8'h08; settle();
    chk("R7 uart no ier bits", irq_oe[4], 0);
    uart_ier = 8'hF0; settle();
    chk("R7 uart high ier bits only", irq_oe[4], 0);
    uart_ier = 8'h02; uart_mcr = 0; settle();
    chk("R7 uart out2 clear", irq_oe[4], 0);
    uart_mcr = 8'h08; settle();
    chk("R7 uart driving", {irq_oe[4], irq_val[4]}, 2'b11);

    // R8 keyboard on line 1
    set_sel(3, 1); kbd_req = 0; settle();
    chk("R8 keyboard claims line", {irq_oe[1], irq_val[1]}, 2'b10);
    kbd_req = 1; settle();
    chk("R8 keyboard value", irq_val[1], 1);

    // R11 conflict on line 4
    chk("R11 no conflict yet", irq_conflict, 0);
    set_sel(3, 4); uart_req = 0; kbd_req = 1; settle();
    chk("R11 conflict raised", irq_conflict, 1);
    chk("R11 shared line OR", {irq_oe[4], irq_val[4]}, 2'b11);
    kbd_req = 0; settle();
    chk("R11 shared line both low", {irq_oe[4], irq_val[4]}, 2'b10);
    chk("R9 line 1 released", {irq_oe[1], irq_val[1]}, 2'b00);

    // R4 select zero
    set_sel(0, 0); settle();
    chk("R4 floppy select zero", irq_oe[6], 0);
    chk("R4 line 0 never driven", irq_oe[0], 0);

    // R1 reset again
    rst_n = 0; settle();
    rst_n = 1; settle();
    chk("R1 all released after reset", irq_oe, 0);
    repeat (4) @(posedge clk);
    finish_run();
  end
endmodule